// File: doc/BRIEF.md
# One-Time-Programmable Memory Program and Verify Controller

This block is the device-side logic of a one-time-programmable byte memory while the part sits in a programming fixture. It decodes four mode pins into a small set of operations: writing a code byte, writing an entry of a 32-byte scrambling table, setting either of two lock bits, reading a code byte back for verification, and reading two fixed identification bytes. A write is not a single strobe. It is a burst of low pulses on a program strobe, and the burst is committed only when it completes while the high programming supply is reported valid.

The scrambling table cannot be read through any mode. Once any entry of it has been written, every verify read returns the bitwise XNOR of the code byte with the table entry selected by the low five address bits. The first lock bit blocks all further code and table writes. The second lock bit blocks those writes and also blanks verification. Either lock bit can still be set after the other one. Cells start erased at all ones and programming can only clear bits. The power-on reset stands in for a blank part and returns every cell to the erased state.

Top module: `otp_prog_ctrl`

## Requirements
- R1: Programming mode is entered only if `psen_pin` was high during the last cycle of the power-on reset (`por_n` low) and is later low while `rst_pin` is high. Once entered, the mode holds until the next power-on reset. Outside programming mode, `dout` is 0xFF.
- R2: `mode_sel` = {P2.7, P2.6, P3.7, P3.6} decodes as follows: 0000 signature read, 0011 verify, 1011 code write, 1010 table write, 1111 lock bit 1, 1100 lock bit 2. In every write mode and in every other code, `dout` is 0xFF.
- R3: In signature read, address 0x30 returns 0x15, address 0x31 returns 0x97, and every other address returns 0xFF.
- R4: A write commits when 25 rising edges of `prog_n` have been counted while `vpp_ok` is high and `mode_sel` holds one write code. The address and data in place at the 25th edge are used. The new cell value is the old value AND `din`, and an erased cell reads 0xFF.
- R5: A partial burst is discarded. The count restarts from zero if `vpp_ok` goes low or if `mode_sel` changes. If `vpp_ok` is low in the cycle of the 25th edge, nothing is written.
- R6: Before any table write, verify returns the stored code byte. `dout` is registered, so it reflects `mode_sel` and `addr` one clock later.
- R7: After any table write, verify returns ~(code[addr] ^ table[addr[4:0]]). Table entries start at 0xFF and are also programmed by AND.
- R8: No mode code places a table entry on `dout`.
- R9: With either lock bit set, code writes and table writes have no effect. With only lock bit 1 set, verify still works.
- R10: Lock bit 2 can be set while lock bit 1 is already set.
- R11: With lock bit 2 set, verify returns 0xFF, and signature read still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| psen_pin | input | 1 | Program-store-enable pin level |
| rst_pin | input | 1 | Device reset pin level, active high |
| mode_sel | input | 4 | Mode pins {P2.7, P2.6, P3.7, P3.6} |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| prog_n | input | 1 | Program strobe, pulsed low |
| vpp_ok | input | 1 | Programming supply is within range |
| dout | output | DATA_W | Data port, 0xFF when released |

## Verification
The closing edge of a burst and a loss of the programming supply can occur in the same cycle. The bench provokes this by dropping `vpp_ok` at the negative edge where `prog_n` returns high for the 25th time. It judges the result by a verify read that must show the old cell contents. A second run of 24 pulses must then also leave the cell untouched, which shows that the count was cleared and not merely paused. A burst that spans a mode change is handled the same way. It is split between the code-write and table-write codes, and both the code byte and the scrambled read must stay unchanged.

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TBL_AW = 5,
  parameter int PULSES = 25,
  parameter logic [ADDR_W-1:0] SIG_ADDR = 'h30,
  parameter logic [DATA_W-1:0] SIG_MFR = 'h15,
  parameter logic [DATA_W-1:0] SIG_DEV = 'h97
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              psen_pin,
  input  logic              rst_pin,
  input  logic [3:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              prog_n,
  input  logic              vpp_ok,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TBL_N = 1 << TBL_AW;
  localparam int CW = $clog2(PULSES + 1);
  localparam logic [3:0] MD_SIG  = 4'b0000;
  localparam logic [3:0] MD_VFY  = 4'b0011;
  localparam logic [3:0] MD_CODE = 4'b1011;
  localparam logic [3:0] MD_TBL  = 4'b1010;
  localparam logic [3:0] MD_SEC1 = 4'b1111;
  localparam logic [3:0] MD_SEC2 = 4'b1100;
  localparam logic [DATA_W-1:0] RELEASED = '1;

  logic armed, pmode, prog_q, tbl_set, sec1, sec2;
  logic [3:0] mode_q;
  logic [CW-1:0] cnt;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] tbl [TBL_N];
  logic wr_mode, rise, burst_ok, fire, locked;
  logic [TBL_AW-1:0] key_idx;
  logic [DATA_W-1:0] vfy_byte, sig_byte;

  assign wr_mode  = (mode_sel == MD_CODE) || (mode_sel == MD_TBL) ||
                    (mode_sel == MD_SEC1) || (mode_sel == MD_SEC2);
  assign rise     = ~prog_q & prog_n;
  assign burst_ok = pmode & vpp_ok & wr_mode & (mode_sel == mode_q);
  assign fire     = burst_ok & rise & (cnt == CW'(PULSES - 1));
  assign locked   = sec1 | sec2;
  assign key_idx  = addr[TBL_AW-1:0];

  always_ff @(posedge clk) begin
    if (!por_n) begin
      armed <= psen_pin;
      pmode <= 1'b0;
    end else if (armed && rst_pin && !psen_pin) begin
      pmode <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      prog_q <= 1'b1;
      mode_q <= MD_SIG;
      cnt    <= '0;
    end else begin
      prog_q <= prog_n;
      mode_q <= mode_sel;
      if (!burst_ok)
        cnt <= '0;
      else if (rise)
        cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RELEASED;
      for (int j = 0; j < TBL_N; j++) tbl[j] <= RELEASED;
      tbl_set <= 1'b0;
      sec1    <= 1'b0;
      sec2    <= 1'b0;
    end else if (fire) begin
      case (mode_sel)
        MD_CODE: if (!locked) mem[addr] <= mem[addr] & din;
        MD_TBL: if (!locked) begin
          tbl[key_idx] <= tbl[key_idx] & din;
          tbl_set      <= 1'b1;
        end
        MD_SEC1: sec1 <= 1'b1;
        MD_SEC2: sec2 <= 1'b1;
        default: ;
      endcase
    end
  end

  assign vfy_byte = tbl_set ? ~(mem[addr] ^ tbl[key_idx]) : mem[addr];
  assign sig_byte = (addr == SIG_ADDR) ? SIG_MFR :
                    (addr == ADDR_W'(SIG_ADDR + 1'b1)) ? SIG_DEV : RELEASED;

  always_ff @(posedge clk) begin
    if (!por_n || !pmode)
      dout <= RELEASED;
    else begin
      case (mode_sel)
        MD_VFY:  dout <= sec2 ? RELEASED : vfy_byte;
        MD_SIG:  dout <= sig_byte;
        default: dout <= RELEASED;
      endcase
    end
  end
endmodule

module otp_prog_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CW = 5,
  parameter logic [ADDR_W-1:0] SIG_ADDR = 'h30,
  parameter logic [DATA_W-1:0] SIG_MFR = 'h15
) (
  input logic              clk,
  input logic              por_n,
  input logic              pmode,
  input logic [3:0]        mode_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              vpp_ok,
  input logic [CW-1:0]     cnt,
  input logic              sec1,
  input logic              sec2,
  input logic              tbl_set,
  input logic [DATA_W-1:0] dout
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    !pmode |=> dout == '1);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    pmode |=> pmode);
  // R3
  sig_mfr_chk: assert property (@(posedge clk) disable iff (!por_n)
    (pmode && mode_sel == 4'b0000 && addr == SIG_ADDR) |=> dout == SIG_MFR);
  // R5
  supply_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
    !vpp_ok |=> cnt == '0);
  // R7
  tbl_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    tbl_set |=> tbl_set);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sec1 |=> sec1) and (sec2 |=> sec2));
  // R11
  blank_verify_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sec2 && mode_sel == 4'b0011) |=> dout == '1);
endmodule

bind otp_prog_ctrl otp_prog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW), .SIG_ADDR(SIG_ADDR), .SIG_MFR(SIG_MFR)
) u_chk (
  .clk(clk), .por_n(por_n), .pmode(pmode), .mode_sel(mode_sel), .addr(addr),
  .vpp_ok(vpp_ok), .cnt(cnt), .sec1(sec1), .sec2(sec2), .tbl_set(tbl_set),
  .dout(dout)
);

// File: tb/sim_otp_prog_ctrl.sv
module sim_otp_prog_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n, psen_pin, rst_pin, prog_n, vpp_ok;
  logic [3:0] mode_sel;
  logic [7:0] addr, din;
  logic [7:0] dout;

  otp_prog_ctrl u0 (
    .clk(clk), .por_n(por_n), .psen_pin(psen_pin), .rst_pin(rst_pin),
    .mode_sel(mode_sel), .addr(addr), .din(din), .prog_n(prog_n),
    .vpp_ok(vpp_ok), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, bad = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_tbl [32];
  bit m_tset, m_s1, m_s2, m_pm;

  function automatic logic [7:0] expv(logic [3:0] m, logic [7:0] a);
    if (!m_pm) return 8'hFF;
    if (m == 4'b0011) begin
      if (m_s2) return 8'hFF;
      if (m_tset) return ~(m_mem[a] ^ m_tbl[a[4:0]]);
      return m_mem[a];
    end
    if (m == 4'b0000) return (a == 8'h30) ? 8'h15 : (a == 8'h31) ? 8'h97 : 8'hFF;
    return 8'hFF;
  endfunction

  task automatic chk(string tag, logic [3:0] m, logic [7:0] a);
    @(negedge clk);
    mode_sel = m; addr = a;
    @(negedge clk);
    vectors++;
    if (dout !== expv(m, a)) begin
      bad++;
      $display("FAIL %s mode=%b addr=%h actual=%h expected=%h", tag, m, a, dout, expv(m, a));
    end
  endtask

  task automatic burst(logic [3:0] m, logic [7:0] a, logic [7:0] d, int n, bit drop_last);
    @(negedge clk);
    mode_sel = m; addr = a; din = d; vpp_ok = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) prog_n = 1'b0;
      @(negedge clk) prog_n = 1'b1;
      if (drop_last && i == n - 1) vpp_ok = 1'b0;
    end
    @(negedge clk) vpp_ok = 1'b1;
  endtask

  task automatic prog(logic [3:0] m, logic [7:0] a, logic [7:0] d);
    burst(m, a, d, 25, 1'b0);
    if (m == 4'b1011 && !(m_s1 || m_s2)) m_mem[a] = m_mem[a] & d;
    else if (m == 4'b1010 && !(m_s1 || m_s2)) begin
      m_tbl[a[4:0]] = m_tbl[a[4:0]] & d;
      m_tset = 1'b1;
    end
    else if (m == 4'b1111) m_s1 = 1'b1;
    else if (m == 4'b1100) m_s2 = 1'b1;
  endtask

  task automatic power_up(bit psen_lvl);
    por_n = 1'b0; psen_pin = psen_lvl; rst_pin = 1'b0; prog_n = 1'b1;
    vpp_ok = 1'b0; mode_sel = 4'b0000; addr = 8'h00; din = 8'h00;
    m_pm = 1'b0; m_tset = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < 32; i++) m_tbl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    vectors++;
    if (dout !== 8'hFF) begin
      bad++;
      $display("FAIL R1 reset dout actual=%h expected=ff", dout);
    end
    por_n = 1'b1;
  endtask

  initial begin
    power_up(1'b0);
    rst_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no entry without psen high at power-up", 4'b0000, 8'h30);

    power_up(1'b1);
    repeat (2) @(negedge clk);
    chk("R1 psen still high", 4'b0000, 8'h30);
    psen_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset pin low", 4'b0000, 8'h30);
    rst_pin = 1'b1;
    @(negedge clk);
    m_pm = 1'b1;
    rst_pin = 1'b0;
    chk("R1 mode held after reset pin drops", 4'b0000, 8'h30);

    for (int a = 0; a < 256; a++) chk("R3 signature", 4'b0000, 8'(a));
    for (int a = 0; a < 256; a++) chk("R6 erased verify", 4'b0011, 8'(a));

    for (int a = 0; a < 256; a++) prog(4'b1011, 8'(a), 8'(a * 37) ^ 8'h5A);
    for (int a = 0; a < 256; a++) chk("R4 R6 verify after write", 4'b0011, 8'(a));

    for (int a = 0; a < 256; a += 33) begin
      prog(4'b1011, 8'(a), 8'h0F);
      chk("R4 second write ANDs", 4'b0011, 8'(a));
    end

    burst(4'b1011, 8'h40, 8'h00, 24, 1'b0);
    chk("R5 24 pulses discarded", 4'b0011, 8'h40);
    burst(4'b1011, 8'h40, 8'h00, 25, 1'b1);
    burst(4'b1011, 8'h40, 8'h00, 24, 1'b0);
    chk("R5 supply drop at final edge", 4'b0011, 8'h40);
    prog(4'b1011, 8'h40, 8'h00);
    chk("R4 full burst after drop", 4'b0011, 8'h40);
    burst(4'b1011, 8'h41, 8'h00, 12, 1'b0);
    burst(4'b1010, 8'h41, 8'h00, 13, 1'b0);
    chk("R5 mode change splits burst, code", 4'b0011, 8'h41);
    chk("R5 mode change splits burst, table", 4'b0011, 8'h61);

    for (int i = 0; i < 32; i++) prog(4'b1010, 8'(i), 8'(i * 11) + 8'h3C);
    for (int a = 0; a < 256; a++) chk("R7 scrambled verify", 4'b0011, 8'(a));

    for (int a = 0; a < 256; a += 51)
      for (int m = 0; m < 16; m++) chk("R2 R8 mode sweep", 4'(m), 8'(a));

    prog(4'b1111, 8'h00, 8'h00);
    prog(4'b1011, 8'h10, 8'h00);
    prog(4'b1010, 8'h03, 8'h00);
    for (int a = 0; a < 256; a++) chk("R9 writes blocked, verify live", 4'b0011, 8'(a));

    prog(4'b1100, 8'h00, 8'h00);
    for (int a = 0; a < 256; a += 17) chk("R10 R11 verify blanked", 4'b0011, 8'(a));
    chk("R11 signature after lock", 4'b0000, 8'h30);
    chk("R11 signature after lock", 4'b0000, 8'h31);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule